// File: doc/BRIEF.md
# Sign-Magnitude PCM Frame Serializer

This block turns a stream of signed stereo samples into a serial word stream for a ladder-style converter that expects sign-magnitude data. Each half period of the word clock (`lrck`) carries one 32-bit word for one channel. The word holds a sign flag, a magnitude whose two top bits are expanded into a three-bit thermometer field, and three forced-zero padding positions. The bit clock is a burst: it gives exactly 32 pulses at the start of each half period and then stays low until the word clock changes again.

Samples arrive as left/right pairs over a valid/ready handshake. A buffer of one pair decouples the producer from the frame timing. A pair is taken when a left half period begins. If no pair is waiting at that moment, the previous pair is sent again and a sticky underrun flag is raised. All outputs are registered and run from the system clock. One bit period lasts `2*DIV` system clocks and one half period lasts `SLOTS` bit periods.

Top module: `smpcm_serializer`

## Requirements
- R1: Each `lrck` half period carries exactly 32 rising edges of `bclk`. Frame position 32 is sent on the first rising edge and position 1 on the last.
- R2: After its 32nd pulse, `bclk` stays low until the next `lrck` transition. `lrck` only changes while `bclk` is low.
- R3: Position 1 is the sign: 0 for a sample of zero or more, 1 for a negative sample. The magnitude is the absolute value of the sample, saturated to 2^27-1 so that the most negative 28-bit sample encodes as full scale.
- R4: Positions 9, 17 and 25 are always 0.
- R5: Positions (32,31,30) hold the magnitude bits 26:25 as a thermometer code: 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111.
- R6: Positions 29..26, 24..18, 16..10 and 8..2, taken in that order, carry magnitude bits 24 down to 0.
- R7: `sdata` changes only when `bclk` falls or while `bclk` is low. It never changes at the edge where `bclk` rises or while `bclk` is high.
- R8: `lrck`=0 sends the left sample and `lrck`=1 sends the right sample. A pair accepted while `in_valid` and `in_ready` are both high is sent starting at the next left half period. `in_ready` is low while a pair is waiting.
- R9: If no pair is waiting when a left half period starts, both words repeat the previous pair and `underrun` goes high and stays high until reset.
- R10: During reset, `lrck`=1, `bclk`=0, `sdata`=0, `in_ready`=1 and `underrun`=0. Within a burst, consecutive `bclk` rising edges are `2*DIV` system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample pair is presented |
| in_ready | output | 1 | The pair buffer is empty |
| in_left | input | SAMPLE_W | Signed left sample, two's complement |
| in_right | input | SAMPLE_W | Signed right sample, two's complement |
| bclk | output | 1 | Burst bit clock, idle low |
| lrck | output | 1 | Word clock: 0 left, 1 right |
| sdata | output | 1 | Serial data, most significant position first |
| underrun | output | 1 | Sticky: a left half period began with no pair waiting |

## Verification
The words are checked against the sample patterns that separate each field of the frame:
- zero and minus one, to tell the sign from the magnitude;
- one value for each of the four thermometer codes;
- full-scale positive, and the most negative value, which must saturate;
- alternating bit patterns of both signs, which expose any slip or swap among the 25 lower magnitude bits around the padding positions.

A starved interval is created on purpose, and the words sent during it must repeat the last pair exactly. The underrun flag is read before the starved interval, during it and after the stream resumes. Pulse count, pulse spacing and data edges are measured on every word.

// File: rtl/smpcm_pkg.sv
`timescale 1ns/1ps
package smpcm_pkg;
   localparam int FRAME_BITS = 32;
   localparam int MAG_W      = 27;
   localparam int BURST_TICKS = 2 * FRAME_BITS;

   typedef logic [FRAME_BITS-1:0] frame_t;
   typedef logic [MAG_W-1:0]      mag_t;

   // Index p-1 holds frame position p (1 = sign, 32 = first sent).
   function automatic frame_t smpcm_pack(input logic sign, input mag_t mag);
      frame_t     f;
      logic [4:0] k;
      f    = '0;
      f[0] = sign;
      unique case (mag[26:25])
         2'b00: f[31:29] = 3'b000;
         2'b01: f[31:29] = 3'b001;
         2'b10: f[31:29] = 3'b011;
         default: f[31:29] = 3'b111;
      endcase
      k = 5'd24;
      for (int p = 28; p >= 1; p--) begin
         if (p != 24 && p != 16 && p != 8) begin
            f[p[4:0]] = mag[k];
            k = k - 5'd1;
         end
      end
      return f;
   endfunction
endpackage

// File: rtl/smpcm_tick_gen.sv
`timescale 1ns/1ps
module smpcm_tick_gen #(
   parameter int DIV   = 4,
   parameter int SLOTS = 40
) (
   input  logic clk,
   input  logic rst,
   output logic bclk,
   output logic lrck,
   output logic left_start,
   output logic right_start,
   output logic bit_step
);
   import smpcm_pkg::*;
   localparam int TICKS = 2 * SLOTS;
   localparam int TW    = $clog2(TICKS);
   localparam int DW    = $clog2(DIV);

   if (DIV < 2) begin : g_bad_div
      $error("smpcm_tick_gen: DIV must be at least 2");
   end
   if (SLOTS <= FRAME_BITS) begin : g_bad_slots
      $error("smpcm_tick_gen: SLOTS must exceed the frame length");
   end

   logic [DW-1:0] div_q;
   logic [TW-1:0] t_q, t_n;
   logic          tick, at_start;

   assign tick     = (div_q == DW'(DIV - 1));
   assign t_n      = (t_q == TW'(TICKS - 1)) ? '0 : t_q + 1'b1;
   assign at_start = tick && (t_n == '0);

   assign left_start  = at_start && lrck;
   assign right_start = at_start && !lrck;
   assign bit_step    = tick && !t_n[0] && (t_n != '0) && (t_n < TW'(BURST_TICKS));

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         t_q   <= TW'(TICKS - 1);
         bclk  <= 1'b0;
         lrck  <= 1'b1;
      end else begin
         div_q <= tick ? '0 : div_q + 1'b1;
         if (tick) begin
            t_q  <= t_n;
            bclk <= (t_n < TW'(BURST_TICKS)) && t_n[0];
            if (t_n == '0) lrck <= ~lrck;
         end
      end
   end
endmodule

// File: rtl/smpcm_sample_buf.sv
`timescale 1ns/1ps
module smpcm_sample_buf #(
   parameter int SAMPLE_W = 28
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic signed [SAMPLE_W-1:0] in_left,
   input  logic signed [SAMPLE_W-1:0] in_right,
   input  logic                       take,
   output logic signed [SAMPLE_W-1:0] next_left,
   output logic signed [SAMPLE_W-1:0] cur_right,
   output logic                       underrun
);
   logic                       pend_v;
   logic signed [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r;

   assign in_ready  = !pend_v;
   assign next_left = pend_v ? pend_l : cur_l;
   assign cur_right = cur_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_v   <= 1'b0;
         pend_l   <= '0;
         pend_r   <= '0;
         cur_l    <= '0;
         cur_r    <= '0;
         underrun <= 1'b0;
      end else begin
         if (in_valid && in_ready) begin
            pend_l <= in_left;
            pend_r <= in_right;
            pend_v <= 1'b1;
         end
         if (take) begin
            if (pend_v) begin
               cur_l  <= pend_l;
               cur_r  <= pend_r;
               pend_v <= 1'b0;
            end else begin
               underrun <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/smpcm_frame_enc.sv
`timescale 1ns/1ps
module smpcm_frame_enc #(
   parameter int SAMPLE_W = 28
) (
   input  logic signed [SAMPLE_W-1:0] smp,
   output smpcm_pkg::frame_t          frame
);
   import smpcm_pkg::*;
   localparam int ABS_W = SAMPLE_W - 1;

   if (SAMPLE_W < 3 || ABS_W > MAG_W) begin : g_bad_w
      $error("smpcm_frame_enc: SAMPLE_W must lie in 3..28");
   end

   logic [SAMPLE_W-1:0] raw, absv;
   logic [ABS_W-1:0]    sat;
   logic                neg;
   mag_t                mag;

   assign raw  = smp;
   assign neg  = raw[SAMPLE_W-1];
   assign absv = neg ? (~raw + 1'b1) : raw;
   assign sat  = absv[SAMPLE_W-1] ? '1 : absv[ABS_W-1:0];

   if (ABS_W == MAG_W) begin : g_full
      assign mag = sat;
   end else begin : g_left_just
      assign mag = {sat, {(MAG_W - ABS_W){1'b0}}};
   end

   assign frame = smpcm_pack(neg, mag);
endmodule

// File: rtl/smpcm_serializer.sv
`timescale 1ns/1ps
module smpcm_serializer #(
   parameter int SAMPLE_W = 28,
   parameter int DIV      = 4,
   parameter int SLOTS    = 40
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic signed [SAMPLE_W-1:0] in_left,
   input  logic signed [SAMPLE_W-1:0] in_right,
   output logic                       bclk,
   output logic                       lrck,
   output logic                       sdata,
   output logic                       underrun
);
   import smpcm_pkg::*;

   logic                       left_start, right_start, bit_step;
   logic signed [SAMPLE_W-1:0] next_left, cur_right, enc_in;
   frame_t                     enc, sreg;

   smpcm_tick_gen #(.DIV(DIV), .SLOTS(SLOTS)) u_tick (
      .clk(clk), .rst(rst), .bclk(bclk), .lrck(lrck),
      .left_start(left_start), .right_start(right_start), .bit_step(bit_step)
   );

   smpcm_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_left(in_left), .in_right(in_right), .take(left_start),
      .next_left(next_left), .cur_right(cur_right), .underrun(underrun)
   );

   assign enc_in = left_start ? next_left : cur_right;

   smpcm_frame_enc #(.SAMPLE_W(SAMPLE_W)) u_enc (
      .smp(enc_in), .frame(enc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg  <= '0;
         sdata <= 1'b0;
      end else if (left_start || right_start) begin
         sreg  <= enc;
         sdata <= enc[FRAME_BITS-1];
      end else if (bit_step) begin
         sdata <= sreg[FRAME_BITS-2];
         sreg  <= {sreg[FRAME_BITS-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/smpcm_serializer_checker.sv
`timescale 1ns/1ps
module smpcm_serializer_checker (
   input logic clk,
   input logic rst,
   input logic lrck,
   input logic bclk,
   input logic sdata,
   input logic in_valid,
   input logic in_ready,
   input logic underrun
);
   logic       lrck_q, bclk_q, primed, b32, b31;
   logic [5:0] cnt;
   logic       rise, edge_lr;

   assign rise    = bclk && !bclk_q;
   assign edge_lr = lrck != lrck_q;

   always_ff @(posedge clk) begin
      lrck_q <= lrck;
      bclk_q <= bclk;
      if (rst) begin
         cnt    <= '0;
         primed <= 1'b0;
         b32    <= 1'b0;
         b31    <= 1'b0;
      end else if (edge_lr) begin
         cnt    <= '0;
         primed <= 1'b1;
      end else if (rise) begin
         cnt <= cnt + 6'd1;
         if (cnt == 6'd0) b32 <= sdata;
         if (cnt == 6'd1) b31 <= sdata;
      end
   end

   p_full_frame_r1: assert property (@(posedge clk) disable iff (rst)
      (edge_lr && primed) |-> (cnt == 6'd32));
   p_burst_len_r2: assert property (@(posedge clk) disable iff (rst)
      rise |-> (cnt < 6'd32));
   p_lrck_idle_r2: assert property (@(posedge clk) disable iff (rst)
      edge_lr |-> !bclk);
   p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (rise && (cnt == 6'd7 || cnt == 6'd15 || cnt == 6'd23)) |-> !sdata);
   p_thermo_hi_r5: assert property (@(posedge clk) disable iff (rst)
      (rise && cnt == 6'd1 && b32) |-> sdata);
   p_thermo_lo_r5: assert property (@(posedge clk) disable iff (rst)
      (rise && cnt == 6'd2 && b31) |-> sdata);
   p_data_stable_r7: assert property (@(posedge clk) disable iff (rst)
      bclk |-> $stable(sdata));
   p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);
   p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      underrun |=> underrun);
endmodule

bind smpcm_serializer smpcm_serializer_checker u_chk (
   .clk(clk), .rst(rst), .lrck(lrck), .bclk(bclk), .sdata(sdata),
   .in_valid(in_valid), .in_ready(in_ready), .underrun(underrun)
);

// File: tb/smpcm_serializer_bench.sv
`timescale 1ns/1ps
module smpcm_serializer_bench;
   localparam int SW  = 28;
   localparam int DIV = 4;

   logic                 clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
   logic signed [SW-1:0] in_left = '0, in_right = '0;
   logic                 in_ready, bclk, lrck, sdata, underrun;

   smpcm_serializer #(.SAMPLE_W(SW), .DIV(DIV), .SLOTS(40)) u_smpcm_serializer (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_left(in_left), .in_right(in_right), .bclk(bclk), .lrck(lrck),
      .sdata(sdata), .underrun(underrun)
   );

   always #2 clk = ~clk;

   int          n_cmp = 0, n_bad = 0;
   logic [32:0] exp_q[$];
   bit          done = 0, ended = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] model(input logic signed [SW-1:0] s);
      logic signed [SW:0] w;
      logic [26:0]        m;
      logic [31:0]        e;
      int                 nxt;
      w = s;
      if (w < 0) w = -w;
      if (w > 29'sd134217727) w = 29'sd134217727;
      m   = w[26:0];
      e   = '0;
      nxt = 24;
      for (int p = 32; p >= 1; p--) begin
         if (p == 1)                          e[p-1] = (s < 0);
         else if (p == 32)                    e[p-1] = (m[26:25] == 2'b11);
         else if (p == 31)                    e[p-1] = m[26];
         else if (p == 30)                    e[p-1] = (m[26:25] != 2'b00);
         else if (p == 25 || p == 17 || p == 9) e[p-1] = 1'b0;
         else begin
            e[p-1] = m[nxt];
            nxt--;
         end
      end
      return e;
   endfunction

   task automatic push_pair(input logic signed [SW-1:0] l, input logic signed [SW-1:0] r);
      exp_q.push_back({1'b0, model(l)});
      exp_q.push_back({1'b1, model(r)});
   endtask

   task automatic send_pair(input logic signed [SW-1:0] l, input logic signed [SW-1:0] r);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_left  = l;
      in_right = r;
      @(negedge clk);
      in_valid = 1'b0;
      push_pair(l, r);
   endtask

   // Monitor: rebuilds each word from the port activity and scores it.
   initial begin
      logic        pb = 0, pl = 1, psd = 0, started = 0;
      logic [31:0] bits = '0;
      int          rises = 0, cyc = 0, last_rise = 0;
      logic [32:0] e;
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst && !done) begin
            if (bclk && sdata != psd)
               check(0, "R7", "sdata moved with bclk high", {31'd0, sdata}, {31'd0, psd});
            if (bclk && !pb) begin
               if (rises > 0)
                  check(cyc - last_rise == 2 * DIV, "R10", "bclk spacing",
                        cyc - last_rise, 2 * DIV);
               last_rise = cyc;
               rises++;
               bits = {bits[30:0], sdata};
            end
            if (lrck != pl) begin
               check(!bclk, "R2", "bclk high at lrck edge", {31'd0, bclk}, 0);
               if (started && exp_q.size() > 0) begin
                  e = exp_q.pop_front();
                  check(rises == 32, "R1", "pulses per half period", rises, 32);
                  check(pl == e[32], "R8", "channel side", {31'd0, pl}, {31'd0, e[32]});
                  check(bits[8] == 0 && bits[16] == 0 && bits[24] == 0, "R4",
                        "padding positions", bits, e[31:0]);
                  check(bits == e[31:0], "R3 R5 R6", "word content", bits, e[31:0]);
               end
               started = 1;
               rises   = 0;
               bits    = '0;
            end
         end
         pb  = bclk;
         pl  = lrck;
         psd = sdata;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(lrck == 1 && bclk == 0 && sdata == 0 && in_ready == 1 && underrun == 0,
            "R10", "reset state", {27'd0, lrck, bclk, sdata, in_ready, underrun}, 32'b10010);
      rst = 1'b0;

      send_pair(28'sd0, -28'sd1);
      send_pair(28'sd134217727, -28'sd134217728);
      send_pair(28'sd33554432, 28'sd67108864);
      send_pair(28'sd100663296, 28'sd5);
      send_pair(28'sh5555555, -28'sh2AAAAAA);
      send_pair(-28'sd134217727, 28'sd256);
      send_pair(28'sd16777216, -28'sd65537);

      wait (in_ready);
      @(negedge clk);
      check(underrun == 0, "R9", "no underrun while fed", {31'd0, underrun}, 0);
      @(negedge lrck);
      push_pair(28'sd16777216, -28'sd65537);
      @(negedge clk);
      check(underrun == 1, "R9", "underrun on starved left start", {31'd0, underrun}, 1);

      send_pair(-28'sd12345678, 28'sd87654321);
      send_pair(28'sd1, -28'sd100663296);

      wait (exp_q.size() == 0);
      @(negedge clk);
      check(underrun == 1, "R9", "underrun stays set", {31'd0, underrun}, 1);
      done = 1;
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule